// File: doc/BRIEF.md
# Timer Event Conversion Trigger Selector

This block turns counter events from a bank of timer channel pairs into conversion-start pulses for an analog-to-digital converter. Each pair has an even and an odd counter. For every pair the block takes the zero, period and duty-compare strobes of both counters, the count direction of both counters, and the current value of the even counter. It also holds a 16-bit free-trigger compare value for each pair. That value is kept apart from the duty compare and is adopted from its input only when the pair's even counter reaches its period. An equality between the even counter and the adopted value is a free-trigger match, and it is qualified by the even counter's direction.

Each pair has a 4-bit source code, an enable and a flag-clear strobe. The source code picks one of sixteen conditions. The first ten come from the pair's own counters. The last six are the up-count and down-count free-trigger matches of pairs 0, 1 and 2, so any pair can fire on any other pair's free comparator. A rising edge of the selected condition gives a one-clock trigger pulse and sets a sticky flag, which stays set until it is cleared.

Top module: `adc_trig_sel`

## Requirements
- R1: During and right after reset, every `trig_o` and `flag_o` bit is 0.
- R2: Source codes 0, 1 and 2 select the even counter's zero strobe, its period strobe, and the OR of zero and period.
- R3: Code 3 selects the even compare strobe while the even counter counts up (`ch_up_i` = 1). Code 4 selects it while the even counter counts down (`ch_up_i` = 0).
- R4: Codes 5 to 9 select the same five conditions as codes 0 to 4, taken from the odd counter (index 2p+1) instead of the even one (index 2p).
- R5: Code 10+2k selects pair k's free-trigger match while its even counter counts up, and code 11+2k selects it while counting down, for k = 0, 1, 2.
- R6: A free-trigger match is `even_cnt_i` equal to the adopted compare value. A new `ft_val_i` is adopted only on a clock where the pair's even period strobe is high, and it is used from the next clock on. The adopted value resets to 0.
- R7: `trig_o` goes high for exactly one clock after the clock edge that first samples the selected condition high. A condition held high for several clocks gives only that one pulse.
- R8: `flag_o` sets together with the trigger pulse and holds until a clock samples `flag_clr_i` high. If a pulse and a clear fall on the same clock, the flag stays set.
- R9: A pair whose `trig_en_i` bit is 0 produces no pulse and its flag does not set.
- R10: Each pair's selection, enable, pulse and flag are independent of the other pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en_i | input | NPAIR | Per-pair trigger enable |
| src_sel_i | input | 4*NPAIR | Per-pair source code, pair p at bits [4p+3:4p] |
| ch_zero_i | input | 2*NPAIR | Counter zero strobes, even channel at 2p, odd at 2p+1 |
| ch_period_i | input | 2*NPAIR | Counter period strobes |
| ch_cmp_i | input | 2*NPAIR | Counter duty-compare strobes |
| ch_up_i | input | 2*NPAIR | Counter direction, 1 = counting up |
| even_cnt_i | input | CW*NPAIR | Even counter value of each pair |
| ft_val_i | input | CW*NPAIR | Pending free-trigger compare value of each pair |
| flag_clr_i | input | NPAIR | Per-pair write-one flag clear |
| trig_o | output | NPAIR | One-clock conversion trigger pulse |
| flag_o | output | NPAIR | Sticky trigger flag |

## Verification
A condition presented before a clock edge shows up on `trig_o` and `flag_o` right after that edge. That is one register of latency, since the edge detector and the flag both sit behind the same edge. The bench drives each stimulus at a falling edge and compares at the next falling edge, half a period after the sampling edge. A free-trigger compare value loaded with a period strobe takes effect one clock later, so the bench returns the strobe to low before it presents a matching counter value. A clear applied together with a pulse is checked at that same sampling point, and the hold that follows is checked one clock later.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   localparam int SEL_W     = 4;
   localparam int N_SRC     = 1 << SEL_W;
   localparam int MAX_PAIRS = 3;
   localparam int FT_BASE   = 10;

   typedef enum logic [SEL_W-1:0] {
      SRC_EV_ZERO = 4'd0,
      SRC_EV_PRD  = 4'd1,
      SRC_EV_ZP   = 4'd2,
      SRC_EV_CUP  = 4'd3,
      SRC_EV_CDN  = 4'd4,
      SRC_OD_ZERO = 4'd5,
      SRC_OD_PRD  = 4'd6,
      SRC_OD_ZP   = 4'd7,
      SRC_OD_CUP  = 4'd8,
      SRC_OD_CDN  = 4'd9,
      SRC_FT0_UP  = 4'd10,
      SRC_FT0_DN  = 4'd11,
      SRC_FT1_UP  = 4'd12,
      SRC_FT1_DN  = 4'd13,
      SRC_FT2_UP  = 4'd14,
      SRC_FT2_DN  = 4'd15
   } trig_src_e;

   typedef struct packed {
      logic zero;
      logic period;
      logic cmp;
      logic up;
   } ch_evt_t;

endpackage

// File: rtl/ftc_unit.sv
module ftc_unit #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          up_i,
   output logic          match_up_o,
   output logic          match_dn_o
);

   logic [CW-1:0] active_q;
   logic          hit;

   // pending value becomes active only at the even counter's period point
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q <= '0;
      else if (load_i) active_q <= val_i;
   end

   assign hit        = (cnt_i == active_q);
   assign match_up_o = hit & up_i;
   assign match_dn_o = hit & ~up_i;

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(active_q));

   assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (active_q == $past(val_i)));

   assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(match_up_o && match_dn_o));

endmodule

// File: rtl/trig_cond_mux.sv
module trig_cond_mux
   import adc_trig_pkg::*;
#(
   parameter int NPAIR = 3
) (
   input  ch_evt_t            ev_even_i,
   input  ch_evt_t            ev_odd_i,
   input  logic [NPAIR-1:0]   ft_up_i,
   input  logic [NPAIR-1:0]   ft_dn_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               cond_o
);

   logic [N_SRC-1:0] src_vec;

   // pair-local counter conditions
   assign src_vec[SRC_EV_ZERO] = ev_even_i.zero;
   assign src_vec[SRC_EV_PRD]  = ev_even_i.period;
   assign src_vec[SRC_EV_ZP]   = ev_even_i.zero | ev_even_i.period;
   assign src_vec[SRC_EV_CUP]  = ev_even_i.cmp & ev_even_i.up;
   assign src_vec[SRC_EV_CDN]  = ev_even_i.cmp & ~ev_even_i.up;
   assign src_vec[SRC_OD_ZERO] = ev_odd_i.zero;
   assign src_vec[SRC_OD_PRD]  = ev_odd_i.period;
   assign src_vec[SRC_OD_ZP]   = ev_odd_i.zero | ev_odd_i.period;
   assign src_vec[SRC_OD_CUP]  = ev_odd_i.cmp & ev_odd_i.up;
   assign src_vec[SRC_OD_CDN]  = ev_odd_i.cmp & ~ev_odd_i.up;

   // free-trigger matches of every pair, codes beyond NPAIR stay quiet
   for (genvar k = 0; k < MAX_PAIRS; k++) begin : g_ft
      if (k < NPAIR) begin : g_live
         assign src_vec[FT_BASE + 2*k]     = ft_up_i[k];
         assign src_vec[FT_BASE + 2*k + 1] = ft_dn_i[k];
      end else begin : g_absent
         assign src_vec[FT_BASE + 2*k]     = 1'b0;
         assign src_vec[FT_BASE + 2*k + 1] = 1'b0;
      end
   end

   assign cond_o = src_vec[sel_i];

endmodule

// File: rtl/trig_edge_flag.sv
module trig_edge_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic cond_i,
   input  logic clr_i,
   output logic trig_o,
   output logic flag_o
);

   logic prev_q;
   logic fire;

   assign fire = en_i & cond_i & ~prev_q;

   // previous condition is tracked even while disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         trig_o <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         prev_q <= cond_i;
         trig_o <= fire;
         flag_o <= fire | (flag_o & ~clr_i);
      end
   end

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   assert_held_cond_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i && $past(cond_i)) |=> !trig_o);

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !trig_o);

   assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> flag_o);

   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(en_i && cond_i)) |=> !flag_o);

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
   import adc_trig_pkg::*;
#(
   parameter int NPAIR = 3,
   parameter int CW    = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPAIR-1:0]      trig_en_i,
   input  logic [NPAIR*SEL_W-1:0] src_sel_i,
   input  logic [2*NPAIR-1:0]    ch_zero_i,
   input  logic [2*NPAIR-1:0]    ch_period_i,
   input  logic [2*NPAIR-1:0]    ch_cmp_i,
   input  logic [2*NPAIR-1:0]    ch_up_i,
   input  logic [NPAIR*CW-1:0]   even_cnt_i,
   input  logic [NPAIR*CW-1:0]   ft_val_i,
   input  logic [NPAIR-1:0]      flag_clr_i,
   output logic [NPAIR-1:0]      trig_o,
   output logic [NPAIR-1:0]      flag_o
);

   localparam int NCH = 2 * NPAIR;

   if (NPAIR < 1 || NPAIR > MAX_PAIRS) begin : g_bad_npair
      $error("NPAIR must lie between 1 and MAX_PAIRS");
   end
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end

   ch_evt_t          ev   [NCH];
   logic [NPAIR-1:0] ft_up;
   logic [NPAIR-1:0] ft_dn;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ev[c] = '{zero:   ch_zero_i[c],
                       period: ch_period_i[c],
                       cmp:    ch_cmp_i[c],
                       up:     ch_up_i[c]};
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic cond;

      ftc_unit #(.CW(CW)) i_ftc (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (ch_period_i[2*p]),
         .val_i      (ft_val_i[p*CW +: CW]),
         .cnt_i      (even_cnt_i[p*CW +: CW]),
         .up_i       (ch_up_i[2*p]),
         .match_up_o (ft_up[p]),
         .match_dn_o (ft_dn[p])
      );

      trig_cond_mux #(.NPAIR(NPAIR)) i_mux (
         .ev_even_i (ev[2*p]),
         .ev_odd_i  (ev[2*p+1]),
         .ft_up_i   (ft_up),
         .ft_dn_i   (ft_dn),
         .sel_i     (src_sel_i[p*SEL_W +: SEL_W]),
         .cond_o    (cond)
      );

      trig_edge_flag i_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_i   (trig_en_i[p]),
         .cond_i (cond),
         .clr_i  (flag_clr_i[p]),
         .trig_o (trig_o[p]),
         .flag_o (flag_o[p])
      );
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (trig_o == '0 && flag_o == '0) || !rst_n);

endmodule

// File: tb/test_adc_trig_sel.sv
`timescale 1ns/1ps
module test_adc_trig_sel;

   localparam int NP = 3;
   localparam int CW = 16;
   localparam int NV = 25;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NP-1:0]       trig_en_i = '0;
   logic [NP*4-1:0]     src_sel_i = '0;
   logic [2*NP-1:0]     ch_zero_i = '0;
   logic [2*NP-1:0]     ch_period_i = '0;
   logic [2*NP-1:0]     ch_cmp_i = '0;
   logic [2*NP-1:0]     ch_up_i = '0;
   logic [NP*CW-1:0]    even_cnt_i = '0;
   logic [NP*CW-1:0]    ft_val_i = '0;
   logic [NP-1:0]       flag_clr_i = '0;
   logic [NP-1:0]       trig_o;
   logic [NP-1:0]       flag_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   adc_trig_sel #(.NPAIR(NP), .CW(CW)) i_adc_trig_sel (.*);

   // {code, ev zero/period/cmp/up, odd zero/period/cmp/up, free hit, expected}
   localparam logic [13:0] VEC [NV] = '{
      {4'd0,  8'b1000_0000, 1'b0, 1'b1},
      {4'd0,  8'b0100_0000, 1'b0, 1'b0},
      {4'd1,  8'b0100_0000, 1'b0, 1'b1},
      {4'd2,  8'b1000_0000, 1'b0, 1'b1},
      {4'd2,  8'b0100_0000, 1'b0, 1'b1},
      {4'd2,  8'b0010_0000, 1'b0, 1'b0},
      {4'd3,  8'b0011_0000, 1'b0, 1'b1},
      {4'd3,  8'b0010_0000, 1'b0, 1'b0},
      {4'd4,  8'b0010_0000, 1'b0, 1'b1},
      {4'd4,  8'b0011_0000, 1'b0, 1'b0},
      {4'd5,  8'b0000_1000, 1'b0, 1'b1},
      {4'd5,  8'b1000_0000, 1'b0, 1'b0},
      {4'd6,  8'b0000_0100, 1'b0, 1'b1},
      {4'd7,  8'b0000_1000, 1'b0, 1'b1},
      {4'd8,  8'b0000_0011, 1'b0, 1'b1},
      {4'd8,  8'b0011_0000, 1'b0, 1'b0},
      {4'd9,  8'b0000_0010, 1'b0, 1'b1},
      {4'd10, 8'b0001_0000, 1'b1, 1'b1},
      {4'd10, 8'b0000_0000, 1'b1, 1'b0},
      {4'd11, 8'b0000_0000, 1'b1, 1'b1},
      {4'd12, 8'b0001_0000, 1'b1, 1'b1},
      {4'd13, 8'b0000_0000, 1'b1, 1'b1},
      {4'd14, 8'b0001_0000, 1'b1, 1'b1},
      {4'd15, 8'b0000_0000, 1'b1, 1'b1},
      {4'd15, 8'b0001_0000, 1'b1, 1'b0}
   };

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // same event pattern on every pair; hit puts each even counter on its free value
   task automatic drive(input logic [7:0] ev, input logic hit);
      for (int p = 0; p < NP; p++) begin
         ch_zero_i[2*p]     = ev[7];
         ch_period_i[2*p]   = ev[6];
         ch_cmp_i[2*p]      = ev[5];
         ch_up_i[2*p]       = ev[4];
         ch_zero_i[2*p+1]   = ev[3];
         ch_period_i[2*p+1] = ev[2];
         ch_cmp_i[2*p+1]    = ev[1];
         ch_up_i[2*p+1]     = ev[0];
         even_cnt_i[p*CW +: CW] = hit ? CW'(100 * (p + 1)) : '0;
      end
   endtask

   function automatic string req_of(input logic [3:0] c);
      if (c <= 4'd2)      return "R2";
      else if (c <= 4'd4) return "R3";
      else if (c <= 4'd9) return "R4";
      else                return "R5";
   endfunction

   initial begin
      for (int p = 0; p < NP; p++) ft_val_i[p*CW +: CW] = CW'(100 * (p + 1));
      repeat (3) @(negedge clk);
      check("R1", "trig in reset", trig_o[0], 1'b0);
      check("R1", "flag in reset", flag_o[0], 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "trig after reset", |trig_o, 1'b0);
      check("R1", "flag after reset", |flag_o, 1'b0);

      // adopt free-trigger values with every pair disabled
      drive(8'b0100_0000, 1'b0);
      @(negedge clk);
      drive(8'b0, 1'b0);
      @(negedge clk);
      trig_en_i = 3'b001;

      for (int v = 0; v < NV; v++) begin
         drive(8'b0, 1'b0);
         src_sel_i[3:0] = VEC[v][13:10];
         flag_clr_i[0]  = 1'b1;
         @(negedge clk);
         flag_clr_i[0]  = 1'b0;
         drive(VEC[v][9:2], VEC[v][1]);
         @(negedge clk);
         check(req_of(VEC[v][13:10]), $sformatf("vector %0d trig", v), trig_o[0], VEC[v][0]);
         check(req_of(VEC[v][13:10]), $sformatf("vector %0d flag", v), flag_o[0], VEC[v][0]);
      end
      drive(8'b0, 1'b0);
      flag_clr_i = '1;
      @(negedge clk);
      flag_clr_i = '0;

      // R7: held condition gives exactly one pulse
      src_sel_i[3:0] = 4'd0;
      drive(8'b1000_0000, 1'b0);
      @(negedge clk);
      check("R7", "first cycle of held cond", trig_o[0], 1'b1);
      @(negedge clk);
      check("R7", "second cycle of held cond", trig_o[0], 1'b0);
      @(negedge clk);
      check("R7", "third cycle of held cond", trig_o[0], 1'b0);
      drive(8'b0, 1'b0);
      @(negedge clk);

      // R8: flag holds, clears, and set wins over clear
      check("R8", "flag held after pulse", flag_o[0], 1'b1);
      flag_clr_i[0] = 1'b1;
      @(negedge clk);
      flag_clr_i[0] = 1'b0;
      check("R8", "flag cleared", flag_o[0], 1'b0);
      drive(8'b1000_0000, 1'b0);
      flag_clr_i[0] = 1'b1;
      @(negedge clk);
      flag_clr_i[0] = 1'b0;
      drive(8'b0, 1'b0);
      check("R8", "set wins over clear", flag_o[0], 1'b1);
      @(negedge clk);
      check("R8", "flag held next cycle", flag_o[0], 1'b1);
      flag_clr_i = '1;
      @(negedge clk);
      flag_clr_i = '0;

      // R9 and R10: pair1 disabled, pair2 watching odd zero, pair0 even zero
      trig_en_i = 3'b101;
      src_sel_i = {4'd5, 4'd0, 4'd0};
      @(negedge clk);
      drive(8'b1000_0000, 1'b0);
      @(negedge clk);
      check("R10", "pair0 fires on even zero", trig_o[0], 1'b1);
      check("R9", "disabled pair1 trig", trig_o[1], 1'b0);
      check("R9", "disabled pair1 flag", flag_o[1], 1'b0);
      check("R10", "pair2 ignores even zero", trig_o[2], 1'b0);
      drive(8'b0000_1000, 1'b0);
      @(negedge clk);
      check("R10", "pair2 fires on odd zero", trig_o[2], 1'b1);
      check("R10", "pair0 quiet on odd zero", trig_o[0], 1'b0);
      drive(8'b0, 1'b0);
      trig_en_i = 3'b001;
      flag_clr_i = '1;
      @(negedge clk);
      flag_clr_i = '0;

      // R6: pending value waits for the period strobe
      src_sel_i[3:0] = 4'd10;
      ft_val_i[CW-1:0] = CW'(150);
      @(negedge clk);
      even_cnt_i[CW-1:0] = CW'(150);
      ch_up_i[0] = 1'b1;
      @(negedge clk);
      check("R6", "pending value not yet used", trig_o[0], 1'b0);
      even_cnt_i[CW-1:0] = '0;
      @(negedge clk);
      even_cnt_i[CW-1:0] = CW'(100);
      @(negedge clk);
      check("R6", "old value still active", trig_o[0], 1'b1);
      even_cnt_i[CW-1:0] = '0;
      ch_period_i[0] = 1'b1;
      @(negedge clk);
      ch_period_i[0] = 1'b0;
      @(negedge clk);
      even_cnt_i[CW-1:0] = CW'(150);
      @(negedge clk);
      check("R6", "new value active after period", trig_o[0], 1'b1);
      drive(8'b0, 1'b0);
      @(negedge clk);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule